// File: doc/BRIEF.md
# Interrupt Vector and Sleep Controller

This block sits next to a small 8-bit processor core. It merges the status flags of several peripherals into seven shared interrupt sources and picks the most urgent pending source. It then presents the 16-bit address of that source's vector pair, with the high byte at the given address and the low byte at the next one. During reset it presents the start-up vector. It also asserts a take strobe and a mask-set request to the core.

The block also runs the low-power modes. A stop strobe shuts down the oscillator and both clock domains, and only the IRQ pin or reset brings them back. A wait strobe halts only the CPU clock. The oscillator and the timer/pulse-accumulator clock keep running, and any eligible interrupt or the IRQ pin resumes execution. A wake-up from either mode uses the ordinary vector of the source that caused it.

Top module: `intvec_sleep_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `vec_addr`=16'hFFFE, `take`=0, `set_mask`=1 and `osc_en`=`cpu_clk_en`=`per_clk_en`=1.
- R2: A lone source produces these vectors: software strobe FFFC, display FFFA, IRQ pin or capture FFF8, timer FFF6, serial bus FFF4, pulse accumulator FFF2, multi-function timer FFF0.
- R3: When several sources are eligible, the one with the highest vector address wins.
- R4: A group requests its vector only when at least one of its flags is set together with that flag's enable bit. The groups are display (5 flags), timer (3), serial bus (3), multi-function timer (2), and pulse accumulator and capture (1 each).
- R5: While `int_mask`=1, every source other than the software strobe is ignored. The software strobe is taken regardless of the mask.
- R6: `take` and `set_mask` go high one cycle after an eligible request is sampled in the run state, together with the matching vector.
- R7: After the edge that samples `stop_strobe`, all three enables are 0. Peripheral flags are then ignored. A sampled `irq_pin` restores all enables on the next edge, and the interrupt is taken one edge later.
- R8: After the edge that samples `wait_strobe`, `cpu_clk_en`=0 while `osc_en` and `per_clk_en` stay 1. An eligible request or `irq_pin` restores `cpu_clk_en`, and the source is taken one edge later with its normal vector.
- R9: When nothing is taken, `take` is 0 and `vec_addr` keeps its last value.
- R10: If a request is eligible in the same cycle as a stop or wait strobe, the interrupt is taken and the strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (reset pin) |
| irq_pin | input | 1 | External interrupt request, active high |
| swi_strobe | input | 1 | Software interrupt strobe from the core |
| stop_strobe | input | 1 | Stop instruction strobe |
| wait_strobe | input | 1 | Wait instruction strobe |
| int_mask | input | 1 | Global interrupt mask from the core |
| disp_flags | input | 5 | Display flyback and row-done flags |
| disp_en | input | 5 | Enables for disp_flags |
| cap_flag | input | 1 | Input capture flag |
| cap_en | input | 1 | Enable for cap_flag |
| tmr_flags | input | 3 | Two compare flags and overflow flag |
| tmr_en | input | 3 | Enables for tmr_flags |
| bus_flags | input | 3 | Serial bus lost, addressed, done flags |
| bus_en | input | 3 | Enables for bus_flags |
| pac_flag | input | 1 | Pulse accumulator overflow flag |
| pac_en | input | 1 | Enable for pac_flag |
| mft_flags | input | 2 | Multi-function timer tick and overflow flags |
| mft_en | input | 2 | Enables for mft_flags |
| vec_addr | output | 16 | High-byte address of the selected vector pair |
| take | output | 1 | Interrupt-take strobe |
| set_mask | output | 1 | Request to set the core's interrupt mask |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Timer and pulse accumulator clock enable |

## Verification
Every output is registered, so the response to inputs sampled at one rising edge is visible after that edge. The exception is a wake-up: the clock enables return at the first edge and the take strobe with its vector follows at the second edge. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the next rising edge. It checks each wake-up at both edges: no take at the first, then the vector at the second.

// File: rtl/intvec_pkg.sv
package intvec_pkg;
  typedef enum logic [1:0] {PM_RUN = 2'd0, PM_STOP = 2'd1, PM_WAIT = 2'd2} pm_state_t;

  // source indices, ordered from most to least urgent
  localparam int SRC_SWI  = 0;
  localparam int SRC_DISP = 1;
  localparam int SRC_IRQ  = 2;
  localparam int SRC_TMR  = 3;
  localparam int SRC_BUS  = 4;
  localparam int SRC_PAC  = 5;
  localparam int SRC_MFT  = 6;
  localparam int NUM_SRC  = 7;
endpackage

// File: rtl/flag_merge.sv
module flag_merge #(
  parameter int W = 2
) (
  input  logic [W-1:0] flags,
  input  logic [W-1:0] en,
  output logic         req
);
  assign req = |(flags & en);
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int              N      = 7,
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hFFFC
) (
  input  logic [N-1:0]      req,
  output logic              any,
  output logic [ADDR_W-1:0] vec
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign offs = ADDR_W'(idx) << 1;
  assign vec  = BASE - offs;
endmodule

// File: rtl/power_fsm.sv
module power_fsm
  import intvec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  input  logic wait_req,
  input  logic wake_stop,
  input  logic wake_wait,
  output logic run,
  output logic osc_en,
  output logic cpu_en,
  output logic per_en
);
  pm_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      PM_RUN: begin
        if (stop_req)      state_nx = PM_STOP;
        else if (wait_req) state_nx = PM_WAIT;
      end
      PM_STOP: if (wake_stop) state_nx = PM_RUN;
      PM_WAIT: if (wake_wait) state_nx = PM_RUN;
      default: state_nx = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PM_RUN;
      osc_en <= 1'b1;
      cpu_en <= 1'b1;
      per_en <= 1'b1;
    end else begin
      state  <= state_nx;
      osc_en <= (state_nx != PM_STOP);
      cpu_en <= (state_nx == PM_RUN);
      per_en <= (state_nx != PM_STOP);
    end
  end

  assign run = (state == PM_RUN);
endmodule

// File: rtl/intvec_sleep_ctrl.sv
module intvec_sleep_ctrl
  import intvec_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFFFE,
  parameter int                DISP_W    = 5,
  parameter int                TMR_W     = 3,
  parameter int                BUS_W     = 3,
  parameter int                MFT_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_pin,
  input  logic              swi_strobe,
  input  logic              stop_strobe,
  input  logic              wait_strobe,
  input  logic              int_mask,
  input  logic [DISP_W-1:0] disp_flags,
  input  logic [DISP_W-1:0] disp_en,
  input  logic              cap_flag,
  input  logic              cap_en,
  input  logic [TMR_W-1:0]  tmr_flags,
  input  logic [TMR_W-1:0]  tmr_en,
  input  logic [BUS_W-1:0]  bus_flags,
  input  logic [BUS_W-1:0]  bus_en,
  input  logic              pac_flag,
  input  logic              pac_en,
  input  logic [MFT_W-1:0]  mft_flags,
  input  logic [MFT_W-1:0]  mft_en,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              take,
  output logic              set_mask,
  output logic              osc_en,
  output logic              cpu_clk_en,
  output logic              per_clk_en
);
  localparam logic [ADDR_W-1:0] FIRST_VEC = RESET_VEC - ADDR_W'(2);
  localparam int                NMASK     = NUM_SRC - 1;

  logic [NUM_SRC-1:0] raw_req;
  logic [NUM_SRC-1:0] elig;
  logic               pick_any;
  logic [ADDR_W-1:0]  pick_vec;
  logic               run;
  logic               take_now;

  assign raw_req[SRC_SWI] = swi_strobe;

  flag_merge #(.W(DISP_W)) u_disp (.flags(disp_flags), .en(disp_en), .req(raw_req[SRC_DISP]));
  flag_merge #(.W(2))      u_irq  (.flags({cap_flag, irq_pin}), .en({cap_en, 1'b1}),
                                   .req(raw_req[SRC_IRQ]));
  flag_merge #(.W(TMR_W))  u_tmr  (.flags(tmr_flags), .en(tmr_en), .req(raw_req[SRC_TMR]));
  flag_merge #(.W(BUS_W))  u_bus  (.flags(bus_flags), .en(bus_en), .req(raw_req[SRC_BUS]));
  flag_merge #(.W(1))      u_pac  (.flags(pac_flag), .en(pac_en), .req(raw_req[SRC_PAC]));
  flag_merge #(.W(MFT_W))  u_mft  (.flags(mft_flags), .en(mft_en), .req(raw_req[SRC_MFT]));

  // the software strobe bypasses the mask; every other source obeys it
  assign elig = {raw_req[NUM_SRC-1:1] & {NMASK{~int_mask}}, raw_req[SRC_SWI]};

  prio_pick #(.N(NUM_SRC), .ADDR_W(ADDR_W), .BASE(FIRST_VEC)) u_pick (
    .req (elig),
    .any (pick_any),
    .vec (pick_vec)
  );

  assign take_now = run & pick_any;

  power_fsm u_pm (
    .clk       (clk),
    .rst       (rst),
    .stop_req  (stop_strobe & ~pick_any),
    .wait_req  (wait_strobe & ~pick_any),
    .wake_stop (irq_pin),
    .wake_wait (irq_pin | (|elig[NUM_SRC-1:1])),
    .run       (run),
    .osc_en    (osc_en),
    .cpu_en    (cpu_clk_en),
    .per_en    (per_clk_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_addr <= RESET_VEC;
      take     <= 1'b0;
      set_mask <= 1'b1;
    end else begin
      take     <= take_now;
      set_mask <= take_now;
      if (take_now) vec_addr <= pick_vec;
    end
  end
endmodule

// File: rtl/intvec_sleep_chk.sv
module intvec_sleep_chk (
  input logic        clk,
  input logic        rst,
  input logic        irq_pin,
  input logic        swi_strobe,
  input logic        int_mask,
  input logic [15:0] vec_addr,
  input logic        take,
  input logic        set_mask,
  input logic        osc_en,
  input logic        cpu_clk_en,
  input logic        per_clk_en
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (vec_addr == 16'hFFFE && !take && set_mask && osc_en && cpu_clk_en && per_clk_en));

  assert_vec_range_R2: assert property (@(posedge clk) disable iff (rst)
    take |-> (vec_addr[0] == 1'b0 && vec_addr <= 16'hFFFC && vec_addr >= 16'hFFF0));

  assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (int_mask && !swi_strobe && cpu_clk_en) |=> !take);

  assert_take_sets_mask_R6: assert property (@(posedge clk) disable iff (rst)
    take |-> set_mask);

  assert_stop_all_off_R7: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (!cpu_clk_en && !per_clk_en && !take));

  assert_stop_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!osc_en && !irq_pin) |=> !osc_en);

  assert_wait_keeps_per_R8: assert property (@(posedge clk) disable iff (rst)
    (osc_en && !cpu_clk_en) |-> (per_clk_en && !take));

  assert_vec_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!take && !$past(rst)) |-> $stable(vec_addr));
endmodule

bind intvec_sleep_ctrl intvec_sleep_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_pin    (irq_pin),
  .swi_strobe (swi_strobe),
  .int_mask   (int_mask),
  .vec_addr   (vec_addr),
  .take       (take),
  .set_mask   (set_mask),
  .osc_en     (osc_en),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en)
);

// File: tb/sim_intvec_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_intvec_sleep_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_pin, swi_strobe, stop_strobe, wait_strobe, int_mask;
  logic [4:0] disp_flags, disp_en;
  logic cap_flag, cap_en, pac_flag, pac_en;
  logic [2:0] tmr_flags, tmr_en, bus_flags, bus_en;
  logic [1:0] mft_flags, mft_en;
  logic [15:0] vec_addr;
  logic take, set_mask, osc_en, cpu_clk_en, per_clk_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intvec_sleep_ctrl u0 (
    .clk(clk), .rst(rst), .irq_pin(irq_pin), .swi_strobe(swi_strobe),
    .stop_strobe(stop_strobe), .wait_strobe(wait_strobe), .int_mask(int_mask),
    .disp_flags(disp_flags), .disp_en(disp_en), .cap_flag(cap_flag), .cap_en(cap_en),
    .tmr_flags(tmr_flags), .tmr_en(tmr_en), .bus_flags(bus_flags), .bus_en(bus_en),
    .pac_flag(pac_flag), .pac_en(pac_en), .mft_flags(mft_flags), .mft_en(mft_en),
    .vec_addr(vec_addr), .take(take), .set_mask(set_mask), .osc_en(osc_en),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en)
  );

  task automatic clr_in();
    irq_pin = 0; swi_strobe = 0; stop_strobe = 0; wait_strobe = 0; int_mask = 0;
    disp_flags = 0; disp_en = 0; cap_flag = 0; cap_en = 0;
    tmr_flags = 0; tmr_en = 0; bus_flags = 0; bus_en = 0;
    pac_flag = 0; pac_en = 0; mft_flags = 0; mft_en = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_take(input string req, input logic [15:0] exp_vec);
    chk(take === 1'b1, req, {15'd0, take}, 16'd1);
    chk(set_mask === 1'b1, req, {15'd0, set_mask}, 16'd1);
    chk(vec_addr === exp_vec, req, vec_addr, exp_vec);
  endtask

  task automatic chk_en(input string req, input logic [2:0] exp);
    chk({osc_en, cpu_clk_en, per_clk_en} === exp, req,
        {13'd0, osc_en, cpu_clk_en, per_clk_en}, {13'd0, exp});
  endtask

  task automatic t_reset();
    clr_in(); rst = 1; step();
    chk(vec_addr === 16'hFFFE, "R1", vec_addr, 16'hFFFE);
    chk(take === 1'b0 && set_mask === 1'b1, "R1", {14'd0, take, set_mask}, 16'd1);
    chk_en("R1", 3'b111);
    rst = 0; step();
  endtask

  task automatic t_single();
    swi_strobe = 1; step(); chk_take("R2 swi", 16'hFFFC);
    clr_in(); step();
    chk(take === 1'b0, "R9", {15'd0, take}, 16'd0);
    chk(vec_addr === 16'hFFFC, "R9", vec_addr, 16'hFFFC);
    disp_flags = 5'b00100; disp_en = 5'b00100; step(); chk_take("R2 disp", 16'hFFFA); clr_in(); step();
    irq_pin = 1; step(); chk_take("R2 irq", 16'hFFF8); clr_in(); step();
    cap_flag = 1; cap_en = 1; step(); chk_take("R2 cap", 16'hFFF8); clr_in(); step();
    tmr_flags = 3'b100; tmr_en = 3'b111; step(); chk_take("R2 tmr", 16'hFFF6); clr_in(); step();
    bus_flags = 3'b010; bus_en = 3'b010; step(); chk_take("R2 bus", 16'hFFF4); clr_in(); step();
    pac_flag = 1; pac_en = 1; step(); chk_take("R6 pac", 16'hFFF2); clr_in(); step();
    mft_flags = 2'b01; mft_en = 2'b11; step(); chk_take("R2 mft", 16'hFFF0); clr_in(); step();
    chk(vec_addr === 16'hFFF0, "R9", vec_addr, 16'hFFF0);
  endtask

  task automatic t_prio();
    disp_flags = 5'b1; disp_en = 5'b1; irq_pin = 1; tmr_flags = 3'b1; tmr_en = 3'b1;
    bus_flags = 3'b1; bus_en = 3'b1; pac_flag = 1; pac_en = 1; mft_flags = 2'b1; mft_en = 2'b1;
    step(); chk_take("R3 all", 16'hFFFA);
    swi_strobe = 1; step(); chk_take("R3 swi", 16'hFFFC);
    clr_in(); tmr_flags = 3'b010; tmr_en = 3'b010; mft_flags = 2'b10; mft_en = 2'b10;
    step(); chk_take("R3 tmr", 16'hFFF6);
    clr_in(); bus_flags = 3'b100; bus_en = 3'b100; pac_flag = 1; pac_en = 1;
    step(); chk_take("R3 bus", 16'hFFF4);
    clr_in(); step();
  endtask

  task automatic t_group();
    disp_flags = 5'h1F; disp_en = 5'h00; tmr_flags = 3'b011; tmr_en = 3'b100; step();
    chk(take === 1'b0, "R4 disabled", {15'd0, take}, 16'd0);
    disp_flags = 5'b01000; disp_en = 5'b01000; step(); chk_take("R4 row", 16'hFFFA);
    clr_in(); step();
  endtask

  task automatic t_mask();
    int_mask = 1; tmr_flags = 3'b111; tmr_en = 3'b111; irq_pin = 1; step();
    chk(take === 1'b0, "R5 masked", {15'd0, take}, 16'd0);
    swi_strobe = 1; step(); chk_take("R5 swi", 16'hFFFC);
    clr_in(); step();
  endtask

  task automatic t_stop();
    stop_strobe = 1; step(); stop_strobe = 0;
    chk_en("R7 stop", 3'b000);
    tmr_flags = 3'b001; tmr_en = 3'b001; step();
    chk_en("R7 ignore", 3'b000);
    chk(take === 1'b0, "R7 ignore", {15'd0, take}, 16'd0);
    clr_in(); irq_pin = 1; step();
    chk_en("R7 wake", 3'b111);
    chk(take === 1'b0, "R7 wake", {15'd0, take}, 16'd0);
    step(); chk_take("R7 vector", 16'hFFF8);
    clr_in(); step();
  endtask

  task automatic t_wait();
    wait_strobe = 1; step(); wait_strobe = 0;
    chk_en("R8 wait", 3'b101);
    int_mask = 1; pac_flag = 1; pac_en = 1; step();
    chk_en("R8 masked", 3'b101);
    int_mask = 0; step();
    chk_en("R8 wake", 3'b111);
    chk(take === 1'b0, "R8 wake", {15'd0, take}, 16'd0);
    step(); chk_take("R8 vector", 16'hFFF2);
    clr_in(); step();
  endtask

  task automatic t_conflict();
    tmr_flags = 3'b010; tmr_en = 3'b010; stop_strobe = 1; step();
    chk_take("R10 stop", 16'hFFF6);
    clr_in(); step();
    chk_en("R10 stop", 3'b111);
    bus_flags = 3'b001; bus_en = 3'b001; wait_strobe = 1; step();
    chk_take("R10 wait", 16'hFFF4);
    clr_in(); step();
    chk_en("R10 wait", 3'b111);
    stop_strobe = 1; step(); clr_in();
    rst = 1; step();
    chk_en("R1 from stop", 3'b111);
    chk(vec_addr === 16'hFFFE, "R1 from stop", vec_addr, 16'hFFFE);
    rst = 0; step();
  endtask

  initial begin
    clr_in();
    t_reset();
    t_single();
    t_prio();
    t_group();
    t_mask();
    t_stop();
    t_wait();
    t_conflict();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule